// File: doc/BRIEF.md
# Clock Register Window with Frozen User Copy

This block presents the control and time registers of a real-time clock as eight bytes at the top of a byte-wide address space of `2**ADDR_W` locations. Software reaches them over a synchronous single-port interface with address, write data, a write strobe, a read strobe and registered read data. The running time counters belong to a separate calendar block. They arrive here as a flat 64-bit vector. On request this block hands a new time back to that calendar block as a load strobe with a 64-bit value.

Software never reads the live counters directly. It reads a user copy, which follows the counters every cycle while it is released. Two bits in the century byte stop the copy from following. The read-freeze bit gives a stable snapshot. The write-freeze bit lets new time fields be staged and then loaded into the counters in one step. The counters keep running in both cases.

The window also carries these functions:
- an oscillator stop bit, which is driven out to the calendar block;
- a frequency-test bit, which replaces the seconds LSB with a 512 Hz square wave supplied from outside;
- a battery flag, which follows an input pin and cannot be written;
- spare bits that act as plain storage.

Top module: `rtc_reg_window`

## Requirements
- R1: Window and byte offsets. The window occupies addresses `2**ADDR_W-8` to `2**ADDR_W-1`. Byte offset 0 is century (time bits [5:0], write-freeze bit 7, read-freeze bit 6). Offset 1 is seconds (time bits [6:0], oscillator stop bit 7). Offset 2 is minutes (time bits [6:0], spare bit 7). Offset 3 is hours (time bits [5:0], spare bits [7:6]). Offset 4 is day (time bits [2:0], spare bits [5:3], frequency-test bit 6, battery flag bit 7). Offset 5 is date (time bits [5:0], spare bits [7:6]). Offset 6 is month (time bits [4:0], spare bits [7:5]). Offset 7 is year (time bits [7:0]). The 64-bit live and load vectors place offset k at bits [8k+7:8k]. A read outside the window returns 0x00, and a write outside the window changes nothing.
- R2: `rdata` is registered. It shows the addressed byte in the cycle after the clock edge that samples `re` high. It holds its value while `re` is low.
- R3: The copy is released when both freeze bits are 0 and the settle window of R7 has expired. While released, the time bits of every byte follow `live_time`, with a delay of one clock.
- R4: While the read-freeze bit is 1, the time bits of the user copy keep the values captured at the edge where the bit was written. This holds however `live_time` moves.
- R5: While the write-freeze bit is 1, the user copy is frozen in the same way. Time bits written by software are kept as written.
- R6: When the write-freeze bit goes from 1 to 0, `load_pulse` is high for exactly one cycle. During that cycle `load_time` carries the time bits of all eight bytes of the user copy, with every non-time bit set to 0.
- R7: After both freeze bits return to 0, the copy stays frozen for `REFRESH_CYCLES` cycles. After that, all bytes refresh from `live_time` together.
- R8: `osc_stop` equals bit 7 of the seconds byte as last written.
- R9: When the frequency-test bit (day bit 6) is 1 and `osc_stop` is 0, seconds bit 0 reads as the `tick_512` input. Otherwise seconds bit 0 reads as stored.
- R10: Day bit 7 always reads as `batt_ok`. Writes to that bit have no effect.
- R11: Spare bits read back what was last written. Tracking never overwrites them.
- R12: Reset (synchronous, active high) has these effects:
  - every stored bit is cleared;
  - `rdata` is 0x00 and `load_pulse` is 0;
  - the copy is released at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| live_time | input | 64 | Running counter values from the calendar block |
| tick_512 | input | 1 | 512 Hz square wave for the frequency test |
| batt_ok | input | 1 | Battery good indication |
| osc_stop | output | 1 | Oscillator stop request to the calendar block |
| load_pulse | output | 1 | One-cycle strobe that loads the counters |
| load_time | output | 64 | Time values to load, one byte per register offset |

## Verification
Some internal faults would not show at the ports until a later read. If the settle counter or a freeze bit held a wrong value, the user copy would follow or ignore `live_time` at the wrong moment. That shows in the next read of a time byte, one cycle after the read strobe. The bench therefore moves `live_time` while the copy is frozen and reads again both inside and after the settle window.

Other faults show at once on dedicated outputs. A wrong stored control bit appears on `osc_stop` at the next edge, and a wrong write-freeze history appears as a missing or extra `load_pulse`. Faults in the spare-bit or battery-flag paths appear on the next read of the affected byte.

// File: rtl/rtc_win_pkg.sv
package rtc_win_pkg;

    localparam int NUM_REGS = 8;
    localparam int BYTE_W   = 8;
    localparam int FLAT_W   = NUM_REGS * BYTE_W;

    typedef enum logic [2:0] {
        REG_CENT  = 3'd0,
        REG_SEC   = 3'd1,
        REG_MIN   = 3'd2,
        REG_HOUR  = 3'd3,
        REG_DAY   = 3'd4,
        REG_DATE  = 3'd5,
        REG_MONTH = 3'd6,
        REG_YEAR  = 3'd7
    } reg_idx_e;

    localparam int CENT_WFRZ_BIT = 7;
    localparam int CENT_RFRZ_BIT = 6;
    localparam int SEC_STOP_BIT  = 7;
    localparam int DAY_FTEST_BIT = 6;
    localparam int DAY_BATT_BIT  = 7;

    typedef struct packed {
        logic     hit;
        reg_idx_e idx;
    } dec_t;

    typedef struct packed {
        logic rd_frz;
        logic wr_frz;
        logic osc_stop;
        logic ftest;
    } ctrl_t;

    // Bits of each byte that come from (and go back to) the running counters
    function automatic logic [7:0] time_mask(reg_idx_e i);
        case (i)
            REG_CENT:  return 8'h3F;
            REG_SEC:   return 8'h7F;
            REG_MIN:   return 8'h7F;
            REG_HOUR:  return 8'h3F;
            REG_DAY:   return 8'h07;
            REG_DATE:  return 8'h3F;
            REG_MONTH: return 8'h1F;
            default:   return 8'hFF;
        endcase
    endfunction

    // Bits that a software write may store
    function automatic logic [7:0] store_mask(reg_idx_e i);
        if (i == REG_DAY) return 8'h7F;
        return 8'hFF;
    endfunction

    function automatic logic [FLAT_W-1:0] flat_time_mask();
        logic [FLAT_W-1:0] m;
        for (int k = 0; k < NUM_REGS; k++)
            m[k*BYTE_W +: BYTE_W] = time_mask(reg_idx_e'(k));
        return m;
    endfunction

endpackage

// File: rtl/rtc_win_decode.sv
module rtc_win_decode
    import rtc_win_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int IDX_W = $clog2(NUM_REGS);

    always_comb begin
        dec.hit = &addr[ADDR_W-1:IDX_W];
        dec.idx = reg_idx_e'(addr[IDX_W-1:0]);
    end

endmodule

// File: rtl/rtc_win_freeze.sv
module rtc_win_freeze #(
    parameter int REFRESH_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_frz,
    input  logic wr_frz,
    output logic track,
    output logic load_pulse
);
    localparam int CNT_W = $clog2(REFRESH_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REFRESH_CYCLES);

    logic [CNT_W-1:0] settle_cnt;
    logic             wr_frz_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            settle_cnt <= CNT_MAX;
            wr_frz_d   <= 1'b0;
        end else begin
            wr_frz_d <= wr_frz;
            if (rd_frz || wr_frz)
                settle_cnt <= '0;
            else if (settle_cnt != CNT_MAX)
                settle_cnt <= settle_cnt + 1'b1;
        end
    end

    always_comb begin
        track      = (settle_cnt == CNT_MAX) && !rd_frz && !wr_frz;
        load_pulse = wr_frz_d && !wr_frz;
    end

endmodule

// File: rtl/rtc_win_regs.sv
module rtc_win_regs
    import rtc_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_idx_e          wr_idx,
    input  logic [7:0]        wdata,
    input  logic              track,
    input  logic [FLAT_W-1:0] live_time,
    output logic [FLAT_W-1:0] user_time,
    output ctrl_t             ctrl
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
        localparam logic [7:0] TM = time_mask(reg_idx_e'(g));
        localparam logic [7:0] SM = store_mask(reg_idx_e'(g));
        logic [7:0] q;

        always_ff @(posedge clk) begin
            if (rst)
                q <= 8'h00;
            else if (wr_en && (wr_idx == reg_idx_e'(g)))
                q <= wdata & SM;
            else if (track)
                q <= (q & ~TM) | (live_time[g*BYTE_W +: BYTE_W] & TM);
        end

        assign user_time[g*BYTE_W +: BYTE_W] = q;
    end

    always_comb begin
        ctrl.rd_frz   = user_time[int'(REG_CENT)*BYTE_W + CENT_RFRZ_BIT];
        ctrl.wr_frz   = user_time[int'(REG_CENT)*BYTE_W + CENT_WFRZ_BIT];
        ctrl.osc_stop = user_time[int'(REG_SEC)*BYTE_W + SEC_STOP_BIT];
        ctrl.ftest    = user_time[int'(REG_DAY)*BYTE_W + DAY_FTEST_BIT];
    end

endmodule

// File: rtl/rtc_reg_window.sv
module rtc_reg_window
    import rtc_win_pkg::*;
#(
    parameter int ADDR_W         = 11,
    parameter int REFRESH_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              we,
    input  logic              re,
    output logic [7:0]        rdata,
    input  logic [63:0]       live_time,
    input  logic              tick_512,
    input  logic              batt_ok,
    output logic              osc_stop,
    output logic              load_pulse,
    output logic [63:0]       load_time
);
    localparam logic [FLAT_W-1:0] TIME_BITS = flat_time_mask();

    dec_t              dec;
    ctrl_t             ctrl;
    logic              track;
    logic              wr_en;
    logic [FLAT_W-1:0] user_time;
    logic [7:0]        view;

    rtc_win_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    assign wr_en = we && dec.hit;

    rtc_win_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (dec.idx),
        .wdata     (wdata),
        .track     (track),
        .live_time (live_time),
        .user_time (user_time),
        .ctrl      (ctrl)
    );

    rtc_win_freeze #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_frz (
        .clk        (clk),
        .rst        (rst),
        .rd_frz     (ctrl.rd_frz),
        .wr_frz     (ctrl.wr_frz),
        .track      (track),
        .load_pulse (load_pulse)
    );

    // Byte presented to software, with the live overrides applied
    always_comb begin
        view = user_time[int'(dec.idx)*BYTE_W +: BYTE_W];
        if (dec.idx == REG_DAY)
            view[DAY_BATT_BIT] = batt_ok;
        if (dec.idx == REG_SEC && ctrl.ftest && !ctrl.osc_stop)
            view[0] = tick_512;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= 8'h00;
        else if (re)
            rdata <= dec.hit ? view : 8'h00;
    end

    assign osc_stop  = ctrl.osc_stop;
    assign load_time = user_time & TIME_BITS;

endmodule

// File: rtl/rtc_reg_window_chk.sv
module rtc_reg_window_chk
    import rtc_win_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              we,
    input logic              re,
    input logic [7:0]        rdata,
    input logic              batt_ok,
    input logic              osc_stop,
    input logic              load_pulse,
    input logic              wr_en,
    input ctrl_t             ctrl,
    input logic [FLAT_W-1:0] user_time
);
    localparam logic [ADDR_W-1:0] SEC_ADDR = {{(ADDR_W-3){1'b1}}, 3'd1};
    localparam logic [ADDR_W-1:0] DAY_ADDR = {{(ADDR_W-3){1'b1}}, 3'd4};
    logic in_win;
    assign in_win = &addr[ADDR_W-1:3];

    assert_outside_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (re && !in_win) |=> (rdata == 8'h00));

    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rdata));

    assert_read_freeze_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(ctrl.rd_frz) && ctrl.rd_frz && !$past(wr_en)) |-> $stable(user_time));

    assert_load_single_R6: assert property (@(posedge clk) disable iff (rst)
        load_pulse |=> !load_pulse);

    assert_load_after_wfall_R6: assert property (@(posedge clk) disable iff (rst)
        load_pulse |-> $fell(ctrl.wr_frz));

    assert_osc_follows_write_R8: assert property (@(posedge clk) disable iff (rst)
        (we && addr == SEC_ADDR) |=> (osc_stop == $past(wdata[SEC_STOP_BIT])));

    assert_batt_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (re && addr == DAY_ADDR) |=> (rdata[DAY_BATT_BIT] == $past(batt_ok)));

endmodule

bind rtc_reg_window rtc_reg_window_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wdata      (wdata),
    .we         (we),
    .re         (re),
    .rdata      (rdata),
    .batt_ok    (batt_ok),
    .osc_stop   (osc_stop),
    .load_pulse (load_pulse),
    .wr_en      (wr_en),
    .ctrl       (ctrl),
    .user_time  (user_time)
);

// File: tb/rtc_reg_window_bench.sv
`timescale 1ns/1ps
module rtc_reg_window_bench;
    localparam int ADDR_W = 11;
    localparam int REF    = 16;
    localparam logic [ADDR_W-1:0] BASE = 11'h7F8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = 8'h00;
    logic              we = 1'b0;
    logic              re = 1'b0;
    logic [7:0]        rdata;
    logic [63:0]       live_time;
    logic              tick_512 = 1'b0;
    logic              batt_ok = 1'b1;
    logic              osc_stop;
    logic              load_pulse;
    logic [63:0]       load_time;

    int n_checks = 0;
    int n_fail   = 0;
    int pulse_cnt = 0;
    logic [63:0] last_load = '0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];
    logic        pend = 1'b0;

    always #2 clk = ~clk;

    rtc_reg_window #(.ADDR_W(ADDR_W), .REFRESH_CYCLES(REF)) u_rtc_reg_window (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .re(re),
        .rdata(rdata), .live_time(live_time), .tick_512(tick_512),
        .batt_ok(batt_ok), .osc_stop(osc_stop), .load_pulse(load_pulse),
        .load_time(load_time)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_live(input int k, input logic [7:0] v);
        live_time[k*8 +: 8] = v;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        addr = a; re = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        re = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Scoreboard monitor: compares read data one cycle after the read strobe
    always @(negedge clk) begin
        if (!rst) begin
            if (pend) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected read", 64'(rdata), 64'hx);
                end else begin
                    check(tag_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
                end
            end
            pend = re;
            if (load_pulse) begin
                pulse_cnt++;
                last_load = load_time;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] held;
        live_time = 64'h24_06_17_03_09_42_15_20;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R12 rdata after reset", 64'(rdata), 64'h00);
        check("R12 load_pulse after reset", 64'(load_pulse), 64'h0);
        check("R12 osc_stop after reset", 64'(osc_stop), 64'h0);

        // R3 / R12: copy released right after reset
        rd(BASE + 0, 8'h20, "R3 century tracks");
        rd(BASE + 1, 8'h15, "R3 seconds tracks");
        rd(BASE + 4, 8'h83, "R3 day tracks with battery flag");
        rd(BASE + 7, 8'h24, "R3 year tracks");

        // R1: outside window
        wr(BASE - 1, 8'hFF);
        rd(BASE + 2, 8'h42, "R1 write below window ignored");
        rd(11'h000, 8'h00, "R1 read outside window");
        rd(BASE - 1, 8'h00, "R1 read just below window");

        set_live(1, 8'h16);
        @(posedge clk);
        rd(BASE + 1, 8'h16, "R3 seconds follows live");

        // R4: read freeze
        wr(BASE + 0, 8'h60);
        set_live(1, 8'h30);
        repeat (3) @(posedge clk);
        rd(BASE + 1, 8'h16, "R4 frozen seconds");
        rd(BASE + 0, 8'h60, "R4 century with read bit");

        // R7: settle window
        wr(BASE + 0, 8'h20);
        rd(BASE + 1, 8'h16, "R7 still frozen inside settle window");
        repeat (REF + 4) @(posedge clk);
        rd(BASE + 1, 8'h30, "R7 refreshed after settle window");

        // R5 / R6: write freeze and load
        wr(BASE + 0, 8'hA0);
        wr(BASE + 1, 8'h45);
        wr(BASE + 2, 8'h12);
        set_live(1, 8'h31);
        repeat (2) @(posedge clk);
        rd(BASE + 1, 8'h45, "R5 staged seconds kept");
        rd(BASE + 2, 8'h12, "R5 staged minutes kept");
        drain();
        check("R6 no pulse while frozen", 64'(pulse_cnt), 64'd0);
        wr(BASE + 0, 8'h20);
        repeat (3) @(posedge clk);
        check("R6 one load pulse", 64'(pulse_cnt), 64'd1);
        check("R6 load bytes 0..2", last_load[23:0], 64'h12_45_20);
        repeat (REF + 4) @(posedge clk);
        rd(BASE + 1, 8'h31, "R7 refreshed after load");

        // R8: oscillator stop
        set_live(1, 8'h30);
        wr(BASE + 1, 8'hB0);
        check("R8 osc_stop set", 64'(osc_stop), 64'h1);
        wr(BASE + 1, 8'h30);
        check("R8 osc_stop cleared", 64'(osc_stop), 64'h0);

        // R9: frequency test
        wr(BASE + 4, 8'h43);
        tick_512 = 1'b1;
        rd(BASE + 1, 8'h31, "R9 test high on seconds LSB");
        rd(BASE + 4, 8'hC3, "R9 day shows test bit");
        tick_512 = 1'b0;
        rd(BASE + 1, 8'h30, "R9 test low on seconds LSB");
        wr(BASE + 1, 8'hB0);
        tick_512 = 1'b1;
        rd(BASE + 1, 8'hB0, "R9 test suppressed while stopped");
        wr(BASE + 1, 8'h30);
        wr(BASE + 4, 8'h03);
        tick_512 = 1'b0;

        // R10: battery flag
        batt_ok = 1'b0;
        rd(BASE + 4, 8'h03, "R10 flag low");
        wr(BASE + 4, 8'h83);
        rd(BASE + 4, 8'h03, "R10 write to flag ignored");
        batt_ok = 1'b1;
        rd(BASE + 4, 8'h83, "R10 flag high");

        // R11: spare bits
        wr(BASE + 2, 8'h80);
        rd(BASE + 2, 8'hC2, "R11 minutes spare bit");
        wr(BASE + 3, 8'hC0);
        rd(BASE + 3, 8'hC9, "R11 hours spare bits");
        wr(BASE + 6, 8'hE0);
        rd(BASE + 6, 8'hE6, "R11 month spare bits");
        wr(BASE + 5, 8'h40);
        rd(BASE + 5, 8'h57, "R11 date spare bits");

        // R2: hold while re low
        drain();
        held = rdata;
        set_live(7, 8'h99);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R2 rdata holds", 64'(rdata), 64'(held));
        rd(BASE + 7, 8'h99, "R3 year follows live");

        drain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule